// File: doc/BRIEF.md
# Halfword Response Buffer

This block holds the reply that a card returns to a command, up to sixteen bytes, and lets software fetch it as a series of 16-bit words from a single register address. When the command engine finishes a command it pulses a capture strobe. The strobe comes with the received bytes, the number of bytes that are valid, and a flag that says whether the reply was good. Every capture first clears the whole buffer. A good reply is then packed two bytes per slot, and the read position goes back to the first slot.

Software reads the buffer by pulsing a read strobe. The word at the current read position appears on the data output during the strobe cycle, and the position moves forward at the next clock edge. Once the reader has gone past the last slot, every further read returns zero and the position stays where it is. The buffer has nine slots. A full sixteen-byte reply therefore leaves the last slot empty.

Top module: `resp_halfword_fifo`

## Requirements
- R1: After reset every slot holds zero and the read position is slot 0, so the first nine reads all return 0x0000.
- R2: On a good capture, received byte 2i is placed in bits [7:0] of slot i and byte 2i+1 in bits [15:8]. Byte j is taken from capBytes[8j+7:8j].
- R3: Bytes at positions equal to or above capCount are stored as zero. Slots at or beyond ceil(capCount/2) read as zero, and with an odd count the upper half of the last filled slot is zero.
- R4: A sixteen-byte capture fills slots 0 to 7, and slot 8 reads as zero.
- R5: Every capture strobe clears all nine slots. When capOk is low, no byte is loaded and the read position does not change.
- R6: A capture with capOk high returns the read position to slot 0.
- R7: A read strobe with no capture in the same cycle returns the slot at the current position on rdData during that cycle and advances the position by one at the clock edge.
- R8: When the position has reached nine, rdData is zero and further reads leave the position at nine.
- R9: When a capture and a read fall in the same cycle, the capture takes priority. After that edge the position is the one the capture sets (slot 0 for a good reply) and not one higher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| capValid | input | 1 | Capture strobe, one pulse for each completed command |
| capOk | input | 1 | The captured reply is good and should be loaded |
| capBytes | input | 128 | Received bytes, byte j in bits [8j+7:8j] |
| capCount | input | 5 | Number of valid received bytes, 0 to 16 |
| rdStrobe | input | 1 | Software read of the buffer register |
| rdData | output | 16 | Slot at the current read position, or zero once the position is past the last slot |

## Verification
The assertions assume that capCount never exceeds sixteen and that the strobe inputs are never unknown after reset. The clock-edge checks on the read position also rely on a capture strobe overriding any read in the same cycle. The random stimulus draws capCount from 0 to 16, sets each strobe from its own random bit, and drives all inputs at the falling edge, so the inputs stay inside these limits. Directed cases cover the awkward combinations: a capture landing on a read, a rejected reply arriving partway through a read-out, odd byte counts, and reads continued past the ninth slot.

// File: rtl/resp_fifo_pkg.sv
package resp_fifo_pkg;
  typedef struct packed {
    logic clearAll;
    logic loadBytes;
  } slotStrobes_t;
endpackage

// File: rtl/resp_fifo_ctrl.sv
module resp_fifo_ctrl
  import resp_fifo_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  localparam int IDX_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capValid,
  input  logic             capOk,
  input  logic             rdStrobe,
  output slotStrobes_t     strb,
  output logic [IDX_W-1:0] rdIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS);

  logic goodCap;
  logic idxAdvance;

  assign goodCap    = capValid && capOk;
  assign idxAdvance = rdStrobe && !capValid && (rdIdx < LAST_IDX);

  always_comb begin
    strb.clearAll  = capValid;
    strb.loadBytes = goodCap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdIdx <= '0;
    else if (goodCap)    rdIdx <= '0;
    else if (idxAdvance) rdIdx <= rdIdx + 1'b1;
  end

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx <= LAST_IDX);

  // R6
  idx_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    capValid && capOk |=> rdIdx == '0);

  // R7
  idx_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !capValid && rdIdx < LAST_IDX |=> rdIdx == $past(rdIdx) + 1'b1);

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !capValid && rdIdx == LAST_IDX |=> rdIdx == LAST_IDX);

  // R5
  idx_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    capValid && !capOk |=> $stable(rdIdx));
endmodule

// File: rtl/resp_fifo_data.sv
module resp_fifo_data
  import resp_fifo_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  parameter int SLOT_W    = 16,
  parameter int MAX_BYTES = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int HALF_W   = SLOT_W / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  slotStrobes_t           strb,
  input  logic [8*MAX_BYTES-1:0] capBytes,
  input  logic [CNT_W-1:0]       capCount,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [SLOT_W-1:0]      rdData
);
  logic [SLOT_W-1:0] slotQ [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int LO_POS = 2 * s;
    localparam int HI_POS = 2 * s + 1;
    logic [HALF_W-1:0] loByte;
    logic [HALF_W-1:0] hiByte;

    if (LO_POS < MAX_BYTES) begin : g_lo
      assign loByte = (int'(capCount) > LO_POS) ? capBytes[8*LO_POS +: 8] : '0;
    end else begin : g_lo_none
      assign loByte = '0;
    end

    if (HI_POS < MAX_BYTES) begin : g_hi
      assign hiByte = (int'(capCount) > HI_POS) ? capBytes[8*HI_POS +: 8] : '0;
    end else begin : g_hi_none
      assign hiByte = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               slotQ[s] <= '0;
      else if (strb.loadBytes) slotQ[s] <= {hiByte, loByte};
      else if (strb.clearAll)  slotQ[s] <= '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (int'(rdIdx) < NUM_SLOTS) rdData = slotQ[rdIdx];
  end

  // R5
  reject_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll && !strb.loadBytes |=> rdData == '0);

  // R8
  past_end_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(rdIdx) >= NUM_SLOTS |-> rdData == '0);
endmodule

// File: rtl/resp_halfword_fifo.sv
module resp_halfword_fifo
  import resp_fifo_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  parameter int SLOT_W    = 16,
  parameter int MAX_BYTES = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   capValid,
  input  logic                   capOk,
  input  logic [8*MAX_BYTES-1:0] capBytes,
  input  logic [CNT_W-1:0]       capCount,
  input  logic                   rdStrobe,
  output logic [SLOT_W-1:0]      rdData
);
  slotStrobes_t     strb;
  logic [IDX_W-1:0] rdIdx;

  resp_fifo_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capOk(capOk),
    .rdStrobe(rdStrobe), .strb(strb), .rdIdx(rdIdx)
  );

  resp_fifo_data #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .MAX_BYTES(MAX_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .capBytes(capBytes),
    .capCount(capCount), .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: tb/resp_halfword_fifo_bench.sv
module resp_halfword_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 9;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         capValid = 1'b0;
  logic         capOk = 1'b0;
  logic [127:0] capBytes = '0;
  logic [4:0]   capCount = '0;
  logic         rdStrobe = 1'b0;
  logic [15:0]  rdData;

  int checks = 0;
  int fails = 0;
  logic [15:0] expSlot [NSLOT];
  int expIdx = 0;

  resp_halfword_fifo u_resp_halfword_fifo (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capOk(capOk),
    .capBytes(capBytes), .capCount(capCount), .rdStrobe(rdStrobe), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expRead();
    return (expIdx < NSLOT) ? expSlot[expIdx] : 16'h0000;
  endfunction

  function automatic logic [127:0] randBytes();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // One cycle: drive after the falling edge, check reads, then update the model at the edge.
  task automatic step(input logic cap, input logic ok, input logic [127:0] b,
                      input int cnt, input logic rd, input string tag);
    @(negedge clk);
    capValid = cap; capOk = ok; capBytes = b; capCount = 5'(cnt); rdStrobe = rd;
    #1;
    if (rd) begin
      checks++;
      if (rdData !== expRead()) begin
        fails++;
        $display("FAIL %s idx=%0d actual=%h expected=%h", tag, expIdx, rdData, expRead());
      end
    end
    @(posedge clk);
    if (cap) begin
      for (int k = 0; k < NSLOT; k++) expSlot[k] = '0;
      if (ok) begin
        for (int j = 0; j < cnt; j++) expSlot[j/2][8*(j%2) +: 8] = b[8*j +: 8];
        expIdx = 0;
      end
    end else if (rd && expIdx < NSLOT) begin
      expIdx++;
    end
  endtask

  task automatic readN(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 0, 1'b1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NSLOT; k++) expSlot[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset contents are zero, and nine reads plus extra run off the end (R8)
    readN(9, "R1");
    readN(2, "R8");

    // R2: packing of a four-byte reply
    step(1'b1, 1'b1, 128'h0000_0000_0000_0000_0000_0000_DDCC_BBAA, 4, 1'b0, "R2");
    readN(3, "R2");

    // R4: full sixteen-byte reply, slot 8 zero, reading past the end (R8)
    step(1'b1, 1'b1, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 16, 1'b0, "R4");
    readN(9, "R4");
    readN(3, "R8");

    // R3: odd byte count leaves upper half and later slots zero
    step(1'b1, 1'b1, randBytes(), 5, 1'b0, "R3");
    readN(5, "R3");

    // R6: good capture mid read-out returns to slot 0
    step(1'b1, 1'b1, randBytes(), 12, 1'b0, "R6");
    readN(2, "R6");

    // R5: rejected reply clears slots and holds the position
    step(1'b1, 1'b0, randBytes(), 12, 1'b0, "R5");
    readN(8, "R5");

    // R9: capture and read in the same cycle
    step(1'b1, 1'b1, randBytes(), 10, 1'b0, "R9");
    readN(3, "R9");
    step(1'b1, 1'b1, randBytes(), 14, 1'b1, "R9");
    readN(2, "R9");
    step(1'b1, 1'b0, randBytes(), 14, 1'b1, "R9");
    readN(1, "R9");

    // R7: random mix
    for (int i = 0; i < 600; i++) begin
      logic cap;
      cap = ($urandom % 8) == 0;
      step(cap, $urandom % 4 != 0, randBytes(), int'($urandom % 17), $urandom % 4 != 0, "R7");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule